// File: doc/BRIEF.md
# Constrained Dominance Comparator

This block decides which of two candidate solutions wins under constrained Pareto dominance. Each candidate supplies a packed vector of unsigned objective scores, all of which are to be minimised, and an unsigned total constraint-violation figure. A candidate is feasible exactly when its violation figure is zero. The decision has three tiers:

- A feasible candidate beats an infeasible one.
- Between two infeasible candidates, the one with the strictly smaller violation wins.
- Between two feasible candidates, the plain Pareto test over the objectives decides.

A request is accepted through a valid/ready handshake. Cases that the violation figures settle are resolved at the accept edge. Two feasible candidates start a serial scan that compares one objective per clock. Two sticky flags record whether A was worse somewhere and whether A was better somewhere. The scan stops early once both flags are set. The outcome is two flags, "A dominates" and "B dominates", qualified by a result-valid bit. The outcome stays stable until the next request is accepted.

Top module: `dom_compare`

## Requirements
- R1: After reset, `req_ready` is 1, and `res_valid`, `a_wins` and `b_wins` are 0.
- R2: If exactly one candidate has a violation of zero, that candidate wins. `res_valid` is 1 in the cycle after the accept edge, with the winner's flag set and the other flag clear.
- R3: If both violations are non-zero, the strictly smaller violation wins, compared unsigned. If the two violations are equal, both flags are 0. The result is ready in the cycle after the accept edge.
- R4: If both violations are zero, `a_wins` is 1 exactly when A is no larger than B in every objective and strictly smaller in at least one. `b_wins` is defined the same way with A and B swapped.
- R5: Identical feasible objective vectors give both flags 0. `a_wins` and `b_wins` are never 1 together.
- R6: Objective k occupies bits [k*OBJ_W +: OBJ_W] of each objective bus. The objectives are compared in the order k = 0, 1, 2, ..., one per cycle, starting in the cycle after the accept edge. If the scan reaches the last objective, the result appears N_OBJ cycles after the accept edge.
- R7: The scan ends at the first index j after which A has been found both worse and better. The result then appears j+1 cycles after the accept edge, with both flags 0.
- R8: `req_ready` is 0 while a scan is running. `req_valid` and the request data have no effect during that time.
- R9: While `res_valid` is 1 and no new request is accepted, `res_valid`, `a_wins` and `b_wins` hold their values. Accepting a new request replaces the result.
- R10: Objectives and violations are compared as unsigned numbers. For example, 16'hFFFF is larger than 16'h0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block can accept a request |
| a_obj | input | N_OBJ*OBJ_W | Objective scores of candidate A, objective k at bits k*OBJ_W |
| b_obj | input | N_OBJ*OBJ_W | Objective scores of candidate B |
| a_viol | input | VIOL_W | Total constraint violation of A, 0 means feasible |
| b_viol | input | VIOL_W | Total constraint violation of B |
| res_valid | output | 1 | The result flags are valid |
| a_wins | output | 1 | A constrained-dominates B |
| b_wins | output | 1 | B constrained-dominates A |

## Verification
The stimulus covers each tier of the decision. Feasible-against-infeasible pairs in both orientations separate the first tier from the violation ranking. Infeasible pairs with smaller, larger and equal violations exercise the strict comparison and the tie case. Feasible pairs cover three shapes:

- Vectors where one side is better in the last objective only, which forces a full-length scan.
- Vectors that conflict at index 1, which must end the scan early.
- Identical vectors, which must report no winner.

A large-versus-small objective value shows that the comparison is unsigned. Holding `req_valid` high with other data during a scan shows that the block ignores requests while busy. The reference model predicts the latency as well as the flags, so a wrong stop index shows up in timing, not only in the result.

// File: rtl/dom_compare.sv
module dom_compare #(
  parameter int N_OBJ  = 3,
  parameter int OBJ_W  = 16,
  parameter int VIOL_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [N_OBJ*OBJ_W-1:0] a_obj,
  input  logic [N_OBJ*OBJ_W-1:0] b_obj,
  input  logic [VIOL_W-1:0]      a_viol,
  input  logic [VIOL_W-1:0]      b_viol,
  output logic                   res_valid,
  output logic                   a_wins,
  output logic                   b_wins
);
  localparam int IW = (N_OBJ > 1) ? $clog2(N_OBJ) : 1;
  localparam logic [IW-1:0] LAST = IW'(N_OBJ - 1);

  logic                   busy;
  logic [IW-1:0]          idx;
  logic [N_OBJ*OBJ_W-1:0] a_q, b_q;
  logic                   worse, better;
  logic [OBJ_W-1:0]       a_arr [N_OBJ];
  logic [OBJ_W-1:0]       b_arr [N_OBJ];

  for (genvar k = 0; k < N_OBJ; k++) begin : g_slice
    assign a_arr[k] = a_q[k*OBJ_W +: OBJ_W];
    assign b_arr[k] = b_q[k*OBJ_W +: OBJ_W];
  end

  wire accept = req_valid && req_ready;
  wire a_feas = (a_viol == '0);
  wire b_feas = (b_viol == '0);
  wire [OBJ_W-1:0] ca = a_arr[idx];
  wire [OBJ_W-1:0] cb = b_arr[idx];
  wire nxt_worse  = worse  | (ca > cb);
  wire nxt_better = better | (ca < cb);
  wire scan_end   = (idx == LAST) || (nxt_worse && nxt_better);

  assign req_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; worse <= 1'b0; better <= 1'b0;
      a_q <= '0; b_q <= '0;
      res_valid <= 1'b0; a_wins <= 1'b0; b_wins <= 1'b0;
    end else if (busy) begin
      worse  <= nxt_worse;
      better <= nxt_better;
      idx    <= idx + 1'b1;
      if (scan_end) begin
        busy      <= 1'b0;
        res_valid <= 1'b1;
        a_wins    <= nxt_better && !nxt_worse;
        b_wins    <= nxt_worse && !nxt_better;
      end
    end else if (accept) begin
      a_q <= a_obj; b_q <= b_obj;
      idx <= '0; worse <= 1'b0; better <= 1'b0;
      if (a_feas && b_feas) begin
        busy <= 1'b1; res_valid <= 1'b0; a_wins <= 1'b0; b_wins <= 1'b0;
      end else begin
        res_valid <= 1'b1;
        if (a_feas != b_feas) begin
          a_wins <= a_feas; b_wins <= b_feas;
        end else begin
          a_wins <= a_viol < b_viol; b_wins <= b_viol < a_viol;
        end
      end
    end
  end

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_wins && b_wins));
  p_feas_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && a_feas && !b_feas |=> res_valid && a_wins && !b_wins);
  p_infeas_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !a_feas && !b_feas && (a_viol == b_viol) |=> res_valid && !a_wins && !b_wins);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !accept |=> res_valid && $stable(a_wins) && $stable(b_wins));
  p_scan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> !res_valid);
endmodule

// File: tb/dom_compare_tb.sv
module dom_compare_tb;
  localparam int NO = 3, OW = 16, VW = 16;
  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [NO*OW-1:0] a_obj = '0, b_obj = '0;
  logic [VW-1:0] a_viol = '0, b_viol = '0;
  logic req_ready, res_valid, a_wins, b_wins;
  int total = 0, bad = 0;
  string tag = "R1";

  dom_compare #(.N_OBJ(NO), .OBJ_W(OW), .VIOL_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .a_obj(a_obj), .b_obj(b_obj), .a_viol(a_viol), .b_viol(b_viol),
    .res_valid(res_valid), .a_wins(a_wins), .b_wins(b_wins));

  always #2 clk = ~clk;

  logic m_busy = 0, m_valid = 0, m_a = 0, m_b = 0, m_pa = 0, m_pb = 0;
  int m_cnt = 0;

  task automatic ref_eval(input logic [NO*OW-1:0] ao, bo, input logic [VW-1:0] av, bv,
                          output logic ad, bd, output int lat);
    int w, b;
    w = 0; b = 0; lat = 0; ad = 0; bd = 0;
    if (av == 0 && bv != 0) ad = 1;
    else if (av != 0 && bv == 0) bd = 1;
    else if (av != 0) begin ad = av < bv; bd = bv < av; end
    else begin
      for (int k = 0; k < NO; k++) begin
        if (ao[k*OW +: OW] > bo[k*OW +: OW]) w = 1;
        if (ao[k*OW +: OW] < bo[k*OW +: OW]) b = 1;
        lat = k + 1;
        if (w == 1 && b == 1) break;
      end
      ad = (b == 1) && (w == 0); bd = (w == 1) && (b == 0);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin m_busy <= 0; m_valid <= 0; m_a <= 0; m_b <= 0; end
    else if (m_busy) begin
      if (m_cnt == 1) begin m_busy <= 0; m_valid <= 1; m_a <= m_pa; m_b <= m_pb; end
      m_cnt <= m_cnt - 1;
    end else if (req_valid) begin
      logic ad, bd; int lat;
      ref_eval(a_obj, b_obj, a_viol, b_viol, ad, bd, lat);
      if (lat == 0) begin m_valid <= 1; m_a <= ad; m_b <= bd; end
      else begin
        m_busy <= 1; m_valid <= 0; m_a <= 0; m_b <= 0;
        m_pa <= ad; m_pb <= bd; m_cnt <= lat;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    total++;
    if (req_ready !== !m_busy || res_valid !== m_valid || a_wins !== m_a || b_wins !== m_b) begin
      bad++;
      $display("FAIL %s: ready/valid/a/b got %b%b%b%b exp %b%b%b%b", tag,
               req_ready, res_valid, a_wins, b_wins, !m_busy, m_valid, m_a, m_b);
    end
  end

  function automatic logic [NO*OW-1:0] vec(input int o0, o1, o2);
    return {OW'(o2), OW'(o1), OW'(o0)};
  endfunction

  task automatic run(input string t, input logic [NO*OW-1:0] ao, bo,
                     input int av, bv, input logic busy_noise);
    tag = t;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    a_obj = ao; b_obj = bo; a_viol = VW'(av); b_viol = VW'(bv); req_valid = 1;
    @(negedge clk);
    if (busy_noise) begin
      a_obj = vec(9, 9, 9); b_obj = '0; a_viol = 0; b_viol = 3;
      repeat (4) @(negedge clk);
    end
    req_valid = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (req_ready !== 1 || res_valid !== 0 || a_wins !== 0 || b_wins !== 0) begin
      bad++; $display("FAIL R1: reset got %b%b%b%b exp 1000", req_ready, res_valid, a_wins, b_wins);
    end
    rst_n = 1;
    run("R2", vec(5, 5, 5), vec(1, 1, 1), 0, 4, 0);
    run("R2", vec(1, 1, 1), vec(5, 5, 5), 2, 0, 0);
    run("R3", vec(1, 1, 1), vec(1, 1, 1), 5, 9, 0);
    run("R3", vec(1, 1, 1), vec(1, 1, 1), 9, 5, 0);
    run("R3", vec(1, 2, 3), vec(3, 2, 1), 7, 7, 0);
    run("R4", vec(1, 2, 3), vec(1, 2, 4), 0, 0, 0);
    run("R6", vec(4, 2, 3), vec(4, 2, 1), 0, 0, 0);
    run("R5", vec(7, 8, 9), vec(7, 8, 9), 0, 0, 0);
    run("R7", vec(1, 5, 0), vec(2, 4, 0), 0, 0, 0);
    run("R7", vec(3, 1, 2), vec(1, 3, 2), 0, 0, 0);
    run("R10", vec(16'hFFFF, 1, 1), vec(1, 1, 1), 0, 0, 0);
    run("R10", vec(0, 0, 0), vec(0, 0, 0), 16'hFFFF, 1, 0);
    run("R8", vec(1, 1, 1), vec(2, 2, 2), 0, 0, 1);
    tag = "R9";
    repeat (8) @(negedge clk);
    tag = "R9";
    a_obj = vec(1, 1, 1); b_obj = vec(1, 1, 1); a_viol = 0; b_viol = 0; req_valid = 1;
    repeat (12) @(negedge clk);
    req_valid = 0;
    repeat (6) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got hang exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule